// File: doc/BRIEF.md
# Physical Register Renamer with Serial Rollback

This block renames the architectural registers of an out-of-order core onto a single pool of physical registers. It holds a speculative map table, a committed (architectural) map table, a circular free list of physical register numbers and an in-order history buffer. Each history slot records the destination architectural register, the newly allocated physical register and the physical register that was mapped to that destination before. Only tags and ready bits are handled here. Data values, the register file array and the scheduler live elsewhere.

At dispatch the block looks up both sources and the destination's current mapping, takes the oldest free physical register, and maps the destination to it with its ready bit cleared. A completion marks an in-flight slot done and sets the ready bit of its new register. The head slot retires in order once it is done: its new register becomes the committed mapping and its previous register goes back to the free list. A rollback request discards a number of the youngest slots, one per cycle, starting at the youngest. Each discarded slot gives its new register back and puts its previous mapping back into the speculative map.

The pool size is fixed at the architectural count plus the history depth. As a result the free list and the in-flight destinations together always account for exactly `ROB_DEPTH` registers.

Top module: `phys_renamer`

## Requirements
- R1: After reset both map tables map architectural register a to physical register a, and every physical register is ready. The free list holds physical registers NUM_ARCH up to NUM_PHYS-1 in ascending pop order, and free_count equals ROB_DEPTH.
- R2: An accepted dispatch reports the source tags from the speculative map and the destination's current mapping as disp_old_tag. Its new tag disp_dst_tag is the oldest free-list entry, and disp_idx is the history slot it takes (slots are used in circular program order). After the accept, the destination maps to the new tag with its ready bit cleared.
- R3: A dispatch with disp_has_dst low takes a history slot but pops no register and leaves the speculative map unchanged. Its retirement and its rollback return nothing to the free list.
- R4: disp_accept is low while sched_full is high, while all ROB_DEPTH slots are in flight, or while a destination is needed and the free list is empty. A refused dispatch changes no state.
- R5: A completion names a history slot. If that slot is in flight, its new tag becomes ready, and a source read of that tag in the same cycle already reports ready. A completion naming a slot that is not in flight is ignored.
- R6: When the head slot is done, ret_valid is high and the slot retires in that cycle, at most one per cycle and in program order. The committed map entry of its destination takes its new tag, and its previous tag is appended to the tail of the free list.
- R7: rb_req with rb_count discards min(rb_count, in-flight count) of the youngest slots, one per cycle, youngest first. rb_busy is high from the next cycle for exactly that many cycles. Each discarded slot restores its destination's speculative mapping to its previous tag and appends its new tag to the free list. A count of zero does nothing.
- R8: In the cycle of rb_req and while rb_busy is high, no dispatch is accepted and no slot retires.
- R9: free_count plus the number of in-flight slots that have a destination always equals ROB_DEPTH, and no register read from the speculative map is on the free list.
- R10: A done slot behind an unfinished head does not retire. Retirement waits for the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_has_dst | input | 1 | Request writes a register |
| disp_dst_arch | input | AW | Destination architectural register |
| disp_src0_arch | input | AW | First source architectural register |
| disp_src1_arch | input | AW | Second source architectural register |
| sched_full | input | 1 | Scheduler has no free slot |
| disp_accept | output | 1 | Dispatch taken this cycle |
| disp_idx | output | IW | History slot given to the request |
| disp_dst_tag | output | TW | New physical register for the destination |
| disp_old_tag | output | TW | Destination's previous physical register |
| disp_src0_tag | output | TW | First source physical register |
| disp_src0_rdy | output | 1 | First source ready |
| disp_src1_tag | output | TW | Second source physical register |
| disp_src1_rdy | output | 1 | Second source ready |
| cmpl_valid | input | 1 | Completion broadcast |
| cmpl_idx | input | IW | History slot that completed |
| ret_valid | output | 1 | Head slot retires this cycle |
| ret_has_dst | output | 1 | Retiring slot has a destination |
| ret_arch | output | AW | Retiring destination architectural register |
| ret_tag | output | TW | Retiring new physical register |
| rb_req | input | 1 | Rollback request |
| rb_count | input | CW | Number of youngest slots to discard |
| rb_busy | output | 1 | Rollback walk in progress |
| arch_rd_idx | input | AW | Committed map read index |
| arch_rd_tag | output | TW | Committed map read data |
| free_count | output | CW | Registers on the free list |

## Verification
The bench runs the block with eight architectural registers and eight slots. It uses a directed fill-to-full sequence, then several thousand mixed cycles, and compares every output in every cycle against a behavioural model. The corner cases it targets are these. A completion arrives in the same cycle as a source read of that tag; a design without bypass would report a stale not-ready source. A younger slot completes before the head; a design that retires out of order would commit the wrong mapping. A rollback asks for more slots than are in flight; a design without clamping would walk past the head and corrupt the free list, which the conservation check catches. A dispatch is attempted during the walk; a design that let it through would allocate against a map that is still being restored. A no-destination slot is retired or rolled back; a design that pushed its unused tag would duplicate a register on the free list.

// File: rtl/rn_pkg.sv
// Package rn_pkg
// Shared types and helpers for the register renamer.
// Assumes every circular pointer is advanced with wrap_step.
package rn_pkg;

    typedef enum logic {
        RB_IDLE = 1'b0,
        RB_WALK = 1'b1
    } rb_state_e;

    // Moves a circular pointer by +1 or -1 within [0, depth).
    function automatic int wrap_step(input int ptr, input bit up, input int depth);
        int nxt;
        if (up) nxt = (ptr == depth - 1) ? 0 : ptr + 1;
        else    nxt = (ptr == 0) ? depth - 1 : ptr - 1;
        return nxt;
    endfunction

endpackage

// File: rtl/rn_map_table.sv
// Module rn_map_table
// Table indexed by architectural register that holds one physical tag per entry.
// It has NRD combinational read ports and one write port. Reset loads the
// identity mapping. The caller guarantees at most one write per cycle.
module rn_map_table #(
    parameter  int NENT = 8,
    parameter  int TW   = 4,
    parameter  int NRD  = 3,
    localparam int IXW  = (NENT > 1) ? $clog2(NENT) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [IXW-1:0] wr_idx,
    input  logic [TW-1:0]  wr_tag,
    input  logic [IXW-1:0] rd_idx [NRD],
    output logic [TW-1:0]  rd_tag [NRD]
);

    logic [TW-1:0] tbl [NENT];

    // Identity mapping on reset, single write otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NENT; i++) tbl[i] <= TW'(i);
        end else if (wr_en) begin
            tbl[wr_idx] <= wr_tag;
        end
    end

    // Independent combinational read ports.
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_tag[g] = tbl[rd_idx[g]];
    end

endmodule

// File: rtl/rn_free_list.sv
// Module rn_free_list
// Circular queue of free physical register numbers. Reset fills it with
// BASE .. BASE+DEPTH-1 in pop order. Supports one push and one pop per cycle.
// Assumes the caller never pops when empty and never pushes when full.
module rn_free_list #(
    parameter  int DEPTH = 8,
    parameter  int TW    = 4,
    parameter  int BASE  = 8,
    localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop_en,
    output logic [TW-1:0] pop_tag,
    input  logic          push_en,
    input  logic [TW-1:0] push_tag,
    output logic          empty,
    output logic [CW-1:0] count
);
    import rn_pkg::*;

    logic [TW-1:0] slots [DEPTH];
    logic [IW-1:0] rd_ptr;
    logic [IW-1:0] wr_ptr;

    assign pop_tag = slots[rd_ptr];
    assign empty   = (count == '0);

    // Queue storage: initial contents on reset, tail write on push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slots[i] <= TW'(BASE + i);
        end else if (push_en) begin
            slots[wr_ptr] <= push_tag;
        end
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= CW'(DEPTH);
        end else begin
            if (pop_en)  rd_ptr <= IW'(wrap_step(int'(rd_ptr), 1'b1, DEPTH));
            if (push_en) wr_ptr <= IW'(wrap_step(int'(wr_ptr), 1'b1, DEPTH));
            count <= count + CW'(push_en) - CW'(pop_en);
        end
    end

endmodule

// File: rtl/rn_history.sv
// Module rn_history
// In-order history buffer. Each slot keeps the destination, the new tag, the
// previous tag and a done flag. It allocates at the tail, retires at the head
// and undoes at the tail. The caller keeps allocate and undo apart, and retire
// and undo apart, in any one cycle.
module rn_history #(
    parameter  int DEPTH = 8,
    parameter  int AW    = 3,
    parameter  int TW    = 4,
    localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_en,
    input  logic          alloc_has,
    input  logic [AW-1:0] alloc_arch,
    input  logic [TW-1:0] alloc_new,
    input  logic [TW-1:0] alloc_old,
    input  logic          cmpl_en,
    input  logic [IW-1:0] cmpl_idx,
    input  logic          ret_en,
    input  logic          undo_en,
    output logic [IW-1:0] tail_idx,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          head_vld,
    output logic          head_done,
    output logic          head_has,
    output logic [AW-1:0] head_arch,
    output logic [TW-1:0] head_new,
    output logic [TW-1:0] head_old,
    output logic          last_has,
    output logic [AW-1:0] last_arch,
    output logic [TW-1:0] last_new,
    output logic [TW-1:0] last_old,
    output logic          cmpl_hit,
    output logic          cmpl_has,
    output logic [TW-1:0] cmpl_tag
);
    import rn_pkg::*;

    typedef struct packed {
        logic          has;
        logic [AW-1:0] arch;
        logic [TW-1:0] new_tag;
        logic [TW-1:0] old_tag;
    } hist_ent_t;

    hist_ent_t     ent  [DEPTH];
    logic [DEPTH-1:0] vld;
    logic [DEPTH-1:0] done;
    logic [IW-1:0] head;
    logic [IW-1:0] tail;
    logic [IW-1:0] last;

    assign last     = IW'(wrap_step(int'(tail), 1'b0, DEPTH));
    assign tail_idx = tail;
    assign full     = (count == CW'(DEPTH));
    assign head_vld = (count != '0);
    assign head_done = done[head];
    assign head_has  = ent[head].has;
    assign head_arch = ent[head].arch;
    assign head_new  = ent[head].new_tag;
    assign head_old  = ent[head].old_tag;
    assign last_has  = ent[last].has;
    assign last_arch = ent[last].arch;
    assign last_new  = ent[last].new_tag;
    assign last_old  = ent[last].old_tag;
    assign cmpl_hit  = vld[cmpl_idx];
    assign cmpl_has  = ent[cmpl_idx].has;
    assign cmpl_tag  = ent[cmpl_idx].new_tag;

    // Slot payload is written only at allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
        end else if (alloc_en) begin
            ent[tail] <= '{has: alloc_has, arch: alloc_arch,
                           new_tag: alloc_new, old_tag: alloc_old};
        end
    end

    // Per-slot in-flight and done flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld  <= '0;
            done <= '0;
        end else begin
            if (cmpl_en && vld[cmpl_idx]) done[cmpl_idx] <= 1'b1;
            if (ret_en) begin
                vld[head]  <= 1'b0;
                done[head] <= 1'b0;
            end
            if (undo_en) begin
                vld[last]  <= 1'b0;
                done[last] <= 1'b0;
            end
            if (alloc_en) begin
                vld[tail]  <= 1'b1;
                done[tail] <= 1'b0;
            end
        end
    end

    // Head, tail and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (ret_en) head <= IW'(wrap_step(int'(head), 1'b1, DEPTH));
            if (alloc_en)     tail <= IW'(wrap_step(int'(tail), 1'b1, DEPTH));
            else if (undo_en) tail <= last;
            count <= count + CW'(alloc_en) - CW'(ret_en) - CW'(undo_en);
        end
    end

endmodule

// File: rtl/phys_renamer.sv
// Module phys_renamer
// Renames architectural registers onto NUM_ARCH+ROB_DEPTH physical registers.
// One dispatch, one completion, one retirement and one rollback step per cycle.
// Ready state is kept per physical register, so a restored mapping keeps the
// readiness of its register. The caller sends completions only for slots that
// are not being rolled back.
module phys_renamer #(
    parameter  int NUM_ARCH  = 8,
    parameter  int ROB_DEPTH = 8,
    localparam int NUM_PHYS  = NUM_ARCH + ROB_DEPTH,
    localparam int AW        = (NUM_ARCH > 1) ? $clog2(NUM_ARCH) : 1,
    localparam int TW        = $clog2(NUM_PHYS),
    localparam int IW        = (ROB_DEPTH > 1) ? $clog2(ROB_DEPTH) : 1,
    localparam int CW        = $clog2(ROB_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          disp_valid,
    input  logic          disp_has_dst,
    input  logic [AW-1:0] disp_dst_arch,
    input  logic [AW-1:0] disp_src0_arch,
    input  logic [AW-1:0] disp_src1_arch,
    input  logic          sched_full,
    output logic          disp_accept,
    output logic [IW-1:0] disp_idx,
    output logic [TW-1:0] disp_dst_tag,
    output logic [TW-1:0] disp_old_tag,
    output logic [TW-1:0] disp_src0_tag,
    output logic          disp_src0_rdy,
    output logic [TW-1:0] disp_src1_tag,
    output logic          disp_src1_rdy,
    input  logic          cmpl_valid,
    input  logic [IW-1:0] cmpl_idx,
    output logic          ret_valid,
    output logic          ret_has_dst,
    output logic [AW-1:0] ret_arch,
    output logic [TW-1:0] ret_tag,
    input  logic          rb_req,
    input  logic [CW-1:0] rb_count,
    output logic          rb_busy,
    input  logic [AW-1:0] arch_rd_idx,
    output logic [TW-1:0] arch_rd_tag,
    output logic [CW-1:0] free_count
);
    import rn_pkg::*;

    // Rollback walk state.
    rb_state_e     rb_state;
    logic [CW-1:0] rb_left;
    logic [CW-1:0] rb_clamp;
    logic          hold;
    logic          undo_en;

    // Free list.
    logic          fl_pop;
    logic          fl_push;
    logic [TW-1:0] fl_push_tag;
    logic [TW-1:0] fl_head_tag;
    logic          fl_empty;
    logic [CW-1:0] fl_count;

    // History buffer.
    logic [IW-1:0] h_tail;
    logic [CW-1:0] h_count;
    logic          h_full;
    logic          h_head_vld, h_head_done, h_head_has;
    logic [AW-1:0] h_head_arch;
    logic [TW-1:0] h_head_new, h_head_old;
    logic          h_last_has;
    logic [AW-1:0] h_last_arch;
    logic [TW-1:0] h_last_new, h_last_old;
    logic          h_cmpl_hit, h_cmpl_has;
    logic [TW-1:0] h_cmpl_tag;

    // Map tables.
    logic          sm_wr_en;
    logic [AW-1:0] sm_wr_idx;
    logic [TW-1:0] sm_wr_tag;
    logic [AW-1:0] sm_rd_idx [3];
    logic [TW-1:0] sm_rd_tag [3];
    logic          am_wr_en;
    logic [AW-1:0] am_rd_idx [1];
    logic [TW-1:0] am_rd_tag [1];

    // Ready bits and wakeup.
    logic [NUM_PHYS-1:0] prdy;
    logic                cmpl_fire;
    logic                wake;

    // Dispatch and retirement are both held during a rollback and in its request cycle.
    assign hold    = (rb_state == RB_WALK) | rb_req;
    assign undo_en = (rb_state == RB_WALK);
    assign rb_busy = undo_en;

    assign disp_accept = disp_valid & ~hold & ~sched_full & ~h_full
                       & (~disp_has_dst | ~fl_empty);
    assign fl_pop      = disp_accept & disp_has_dst;
    assign ret_valid   = ~hold & h_head_vld & h_head_done;
    assign ret_has_dst = h_head_has;
    assign ret_arch    = h_head_arch;
    assign ret_tag     = h_head_new;

    // Returned registers: previous tag on retirement, new tag on undo.
    assign fl_push     = (ret_valid & h_head_has) | (undo_en & h_last_has);
    assign fl_push_tag = undo_en ? h_last_new : h_head_old;

    // Speculative map write: allocation or restore (never in the same cycle).
    always_comb begin
        sm_wr_en  = 1'b0;
        sm_wr_idx = disp_dst_arch;
        sm_wr_tag = fl_head_tag;
        if (fl_pop) begin
            sm_wr_en = 1'b1;
        end else if (undo_en && h_last_has) begin
            sm_wr_en  = 1'b1;
            sm_wr_idx = h_last_arch;
            sm_wr_tag = h_last_old;
        end
    end

    assign sm_rd_idx[0] = disp_src0_arch;
    assign sm_rd_idx[1] = disp_src1_arch;
    assign sm_rd_idx[2] = disp_dst_arch;
    assign am_rd_idx[0] = arch_rd_idx;
    assign am_wr_en     = ret_valid & h_head_has;

    assign disp_idx      = h_tail;
    assign disp_dst_tag  = fl_head_tag;
    assign disp_old_tag  = sm_rd_tag[2];
    assign disp_src0_tag = sm_rd_tag[0];
    assign disp_src1_tag = sm_rd_tag[1];
    assign arch_rd_tag   = am_rd_tag[0];
    assign free_count    = fl_count;

    // Completion wakeup with same-cycle bypass to the source read ports.
    assign cmpl_fire     = cmpl_valid & h_cmpl_hit;
    assign wake          = cmpl_fire & h_cmpl_has;
    assign disp_src0_rdy = prdy[sm_rd_tag[0]] | (wake & (h_cmpl_tag == sm_rd_tag[0]));
    assign disp_src1_rdy = prdy[sm_rd_tag[1]] | (wake & (h_cmpl_tag == sm_rd_tag[1]));

    // Per-register ready bits: set on wakeup, cleared on allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prdy <= '1;
        end else begin
            if (wake)   prdy[h_cmpl_tag]  <= 1'b1;
            if (fl_pop) prdy[fl_head_tag] <= 1'b0;
        end
    end

    assign rb_clamp = (rb_count > h_count) ? h_count : rb_count;

    // Rollback sequencer: counts down the slots to discard, one per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rb_state <= RB_IDLE;
            rb_left  <= '0;
        end else if (rb_state == RB_IDLE) begin
            if (rb_req) begin
                rb_left  <= rb_clamp;
                rb_state <= (rb_clamp != '0) ? RB_WALK : RB_IDLE;
            end
        end else begin
            rb_left <= rb_left - CW'(1);
            if (rb_left == CW'(1)) rb_state <= RB_IDLE;
        end
    end

    rn_free_list #(
        .DEPTH (ROB_DEPTH),
        .TW    (TW),
        .BASE  (NUM_ARCH)
    ) i_free_list (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop_en   (fl_pop),
        .pop_tag  (fl_head_tag),
        .push_en  (fl_push),
        .push_tag (fl_push_tag),
        .empty    (fl_empty),
        .count    (fl_count)
    );

    rn_map_table #(
        .NENT (NUM_ARCH),
        .TW   (TW),
        .NRD  (3)
    ) i_spec_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (sm_wr_en),
        .wr_idx (sm_wr_idx),
        .wr_tag (sm_wr_tag),
        .rd_idx (sm_rd_idx),
        .rd_tag (sm_rd_tag)
    );

    rn_map_table #(
        .NENT (NUM_ARCH),
        .TW   (TW),
        .NRD  (1)
    ) i_arch_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (am_wr_en),
        .wr_idx (h_head_arch),
        .wr_tag (h_head_new),
        .rd_idx (am_rd_idx),
        .rd_tag (am_rd_tag)
    );

    rn_history #(
        .DEPTH (ROB_DEPTH),
        .AW    (AW),
        .TW    (TW)
    ) i_history (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (disp_accept),
        .alloc_has  (disp_has_dst),
        .alloc_arch (disp_dst_arch),
        .alloc_new  (fl_head_tag),
        .alloc_old  (sm_rd_tag[2]),
        .cmpl_en    (cmpl_fire),
        .cmpl_idx   (cmpl_idx),
        .ret_en     (ret_valid),
        .undo_en    (undo_en),
        .tail_idx   (h_tail),
        .count      (h_count),
        .full       (h_full),
        .head_vld   (h_head_vld),
        .head_done  (h_head_done),
        .head_has   (h_head_has),
        .head_arch  (h_head_arch),
        .head_new   (h_head_new),
        .head_old   (h_head_old),
        .last_has   (h_last_has),
        .last_arch  (h_last_arch),
        .last_new   (h_last_new),
        .last_old   (h_last_old),
        .cmpl_hit   (h_cmpl_hit),
        .cmpl_has   (h_cmpl_has),
        .cmpl_tag   (h_cmpl_tag)
    );

endmodule

// File: rtl/rn_renamer_chk.sv
// Module rn_renamer_chk
// Property checker bound into phys_renamer. It keeps its own count of in-flight
// destinations, built from dispatch, retire and undo events, to check that
// registers are conserved.
module rn_renamer_chk #(
    parameter int ROB_DEPTH = 8,
    parameter int TW        = 4,
    parameter int CW        = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          disp_accept,
    input logic          disp_has_dst,
    input logic [TW-1:0] disp_dst_tag,
    input logic [TW-1:0] disp_old_tag,
    input logic          rb_busy,
    input logic          rb_req,
    input logic          ret_valid,
    input logic          ret_has_dst,
    input logic          undo_has,
    input logic          fl_empty,
    input logic [CW-1:0] fl_count,
    input logic [CW-1:0] rob_count
);

    logic [CW:0] dst_live;

    // Independent tally of slots that own a destination register.
    always_ff @(posedge clk) begin
        if (!rst_n) dst_live <= '0;
        else dst_live <= dst_live + (CW+1)'(disp_accept & disp_has_dst)
                                  - (CW+1)'(ret_valid & ret_has_dst)
                                  - (CW+1)'(rb_busy & undo_has);
    end

    AST_NEW_NOT_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_accept && disp_has_dst) |-> (disp_dst_tag != disp_old_tag)); // R2
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_accept && disp_has_dst) |-> !fl_empty); // R4
    AST_RETIRE_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !disp_accept) |=> ($past(rob_count) == rob_count + CW'(1))); // R6
    AST_UNDO_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        rb_busy |=> ($past(rob_count) == rob_count + CW'(1))); // R7
    AST_HOLD_DURING_RB: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_busy || rb_req) |-> (!disp_accept && !ret_valid)); // R8
    AST_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((CW+1)'(fl_count) + dst_live) == (CW+1)'(ROB_DEPTH)); // R9

endmodule

bind phys_renamer rn_renamer_chk #(
    .ROB_DEPTH (ROB_DEPTH),
    .TW        (TW),
    .CW        (CW)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .disp_accept  (disp_accept),
    .disp_has_dst (disp_has_dst),
    .disp_dst_tag (disp_dst_tag),
    .disp_old_tag (disp_old_tag),
    .rb_busy      (rb_busy),
    .rb_req       (rb_req),
    .ret_valid    (ret_valid),
    .ret_has_dst  (ret_has_dst),
    .undo_has     (h_last_has),
    .fl_empty     (fl_empty),
    .fl_count     (fl_count),
    .rob_count    (h_count)
);

// File: tb/test_phys_renamer.sv
// Bench for phys_renamer: a behavioural model of the maps, the free queue and
// the history slots predicts every output in every cycle.
module test_phys_renamer;
    localparam int CLK_PERIOD = 10;
    localparam int NA = 8;
    localparam int D  = 8;
    localparam int NP = NA + D;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       disp_valid = 0, disp_has_dst = 0, sched_full = 0;
    logic [2:0] disp_dst_arch = 0, disp_src0_arch = 0, disp_src1_arch = 0;
    logic       disp_accept;
    logic [2:0] disp_idx;
    logic [3:0] disp_dst_tag, disp_old_tag, disp_src0_tag, disp_src1_tag;
    logic       disp_src0_rdy, disp_src1_rdy;
    logic       cmpl_valid = 0;
    logic [2:0] cmpl_idx = 0;
    logic       ret_valid, ret_has_dst;
    logic [2:0] ret_arch;
    logic [3:0] ret_tag;
    logic       rb_req = 0;
    logic [3:0] rb_count = 0;
    logic       rb_busy;
    logic [2:0] arch_rd_idx = 0;
    logic [3:0] arch_rd_tag;
    logic [3:0] free_count;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // Reference state.
    int m_map [NA];
    int m_amap [NA];
    bit m_rdy [NP];
    int fq [D];
    int fhead, fcnt;
    bit r_has [D];
    int r_arch [D], r_new [D], r_old [D];
    bit r_done [D];
    int rhead, rcount;
    bit m_rb;
    int m_left;

    always #(CLK_PERIOD/2) clk = ~clk;

    phys_renamer #(.NUM_ARCH(NA), .ROB_DEPTH(D)) i_phys_renamer (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_has_dst(disp_has_dst),
        .disp_dst_arch(disp_dst_arch), .disp_src0_arch(disp_src0_arch),
        .disp_src1_arch(disp_src1_arch), .sched_full(sched_full),
        .disp_accept(disp_accept), .disp_idx(disp_idx),
        .disp_dst_tag(disp_dst_tag), .disp_old_tag(disp_old_tag),
        .disp_src0_tag(disp_src0_tag), .disp_src0_rdy(disp_src0_rdy),
        .disp_src1_tag(disp_src1_tag), .disp_src1_rdy(disp_src1_rdy),
        .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx),
        .ret_valid(ret_valid), .ret_has_dst(ret_has_dst),
        .ret_arch(ret_arch), .ret_tag(ret_tag),
        .rb_req(rb_req), .rb_count(rb_count), .rb_busy(rb_busy),
        .arch_rd_idx(arch_rd_idx), .arch_rd_tag(arch_rd_tag),
        .free_count(free_count)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit on_free(input int t);
        for (int k = 0; k < fcnt; k++) if (fq[(fhead + k) % D] == t) return 1;
        return 0;
    endfunction

    function automatic int dst_live();
        int n = 0;
        for (int k = 0; k < rcount; k++) if (r_has[(rhead + k) % D]) n++;
        return n;
    endfunction

    task automatic push_free(input int t);
        fq[(fhead + fcnt) % D] = t;
        fcnt++;
    endtask

    // One clock cycle: drive, check against the model, then advance the model.
    task automatic step(input bit dv, input bit hd, input int dst, input int s0, input int s1,
                        input bit sf, input bit cv, input int ci, input bit rq, input int rc);
        int tail, wtag, e0, e1, nt;
        bit hold, cvalid, wake, eacc, eret;
        disp_valid = dv; disp_has_dst = hd; disp_dst_arch = 3'(dst);
        disp_src0_arch = 3'(s0); disp_src1_arch = 3'(s1); sched_full = sf;
        cmpl_valid = cv; cmpl_idx = 3'(ci); rb_req = rq; rb_count = 4'(rc);
        arch_rd_idx = 3'(s0);
        #1;
        tail   = (rhead + rcount) % D;
        hold   = m_rb | rq;
        cvalid = cv && (((ci - rhead + D) % D) < rcount);
        wake   = cvalid && r_has[ci];
        wtag   = r_new[ci];
        eacc   = dv && !hold && !sf && (rcount < D) && (!hd || fcnt > 0);
        eret   = !hold && (rcount > 0) && r_done[rhead];
        e0 = m_map[s0]; e1 = m_map[s1];
        chk(hold ? "R8" : (hd ? "R4" : "R3"), "disp_accept", int'(disp_accept), int'(eacc));
        if (eacc) begin
            chk("R2", "disp_idx", int'(disp_idx), tail);
            chk("R2", "disp_old_tag", int'(disp_old_tag), m_map[dst]);
            if (hd) chk("R2", "disp_dst_tag", int'(disp_dst_tag), fq[fhead]);
        end
        chk("R2", "src0_tag", int'(disp_src0_tag), e0);
        chk("R2", "src1_tag", int'(disp_src1_tag), e1);
        chk("R5", "src0_rdy", int'(disp_src0_rdy), int'(m_rdy[e0] || (wake && wtag == e0)));
        chk("R5", "src1_rdy", int'(disp_src1_rdy), int'(m_rdy[e1] || (wake && wtag == e1)));
        chk("R6", "arch_rd_tag", int'(arch_rd_tag), m_amap[s0]);
        chk("R9", "mapped_not_free", int'(on_free(int'(disp_src0_tag))), 0);
        chk(hold ? "R8" : "R10", "ret_valid", int'(ret_valid), int'(eret));
        if (eret) begin
            chk("R6", "ret_has_dst", int'(ret_has_dst), int'(r_has[rhead]));
            if (r_has[rhead]) begin
                chk("R6", "ret_tag", int'(ret_tag), r_new[rhead]);
                chk("R6", "ret_arch", int'(ret_arch), r_arch[rhead]);
            end
        end
        chk("R7", "rb_busy", int'(rb_busy), int'(m_rb));
        chk("R9", "free_count", int'(free_count), fcnt);
        chk("R9", "conservation", int'(free_count) + dst_live(), D);
        @(posedge clk);
        if (cvalid) begin
            r_done[ci] = 1;
            if (wake) m_rdy[wtag] = 1;
        end
        if (eacc) begin
            nt = 0;
            if (hd) begin
                nt = fq[fhead]; fhead = (fhead + 1) % D; fcnt--;
                m_rdy[nt] = 0;
            end
            r_has[tail] = hd; r_arch[tail] = dst; r_new[tail] = nt;
            r_old[tail] = m_map[dst]; r_done[tail] = 0;
            if (hd) m_map[dst] = nt;
            rcount++;
        end
        if (eret) begin
            if (r_has[rhead]) begin
                m_amap[r_arch[rhead]] = r_new[rhead];
                push_free(r_old[rhead]);
            end
            r_done[rhead] = 0;
            rhead = (rhead + 1) % D; rcount--;
        end
        if (m_rb) begin
            nt = (rhead + rcount - 1) % D;
            if (r_has[nt]) begin
                push_free(r_new[nt]);
                m_map[r_arch[nt]] = r_old[nt];
            end
            r_done[nt] = 0;
            rcount--; m_left--;
            if (m_left == 0) m_rb = 0;
        end else if (rq) begin
            m_left = (rc > rcount) ? rcount : rc;
            m_rb = (m_left != 0);
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(0, 0, 0, k % NA, (k + 3) % NA, 0, 0, 0, 0, 0);
    endtask

    task automatic complete(input int idx);
        step(0, 0, 0, 0, 1, 0, 1, idx, 0, 0);
    endtask

    initial begin
        for (int a = 0; a < NA; a++) begin m_map[a] = a; m_amap[a] = a; end
        for (int p = 0; p < NP; p++) m_rdy[p] = 1;
        for (int k = 0; k < D; k++) begin
            fq[k] = NA + k; r_has[k] = 0; r_arch[k] = 0; r_new[k] = 0; r_old[k] = 0; r_done[k] = 0;
        end
        fhead = 0; fcnt = D; rhead = 0; rcount = 0; m_rb = 0; m_left = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: identity mappings, all ready, full free list.
        for (int a = 0; a < NA; a++) begin
            @(negedge clk);
            disp_src0_arch = 3'(a); arch_rd_idx = 3'(a);
            #1;
            chk("R1", "reset spec map", int'(disp_src0_tag), a);
            chk("R1", "reset ready", int'(disp_src0_rdy), 1);
            chk("R1", "reset arch map", int'(arch_rd_tag), a);
        end
        chk("R1", "reset free_count", int'(free_count), D);
        @(negedge clk);
        // R2/R1: fill every slot; new tags come out in ascending order.
        for (int i = 0; i < D; i++) begin
            chk("R1", "free order", fq[fhead], NA + i);
            step(1, 1, i % NA, (i + 7) % NA, i % NA, 0, 0, 0, 0, 0);
        end
        // R4: full history and empty free list refuse a dispatch.
        step(1, 1, 2, 0, 1, 0, 0, 0, 0, 0);
        step(1, 0, 2, 0, 1, 0, 0, 0, 0, 0);
        // R10: younger slots done, head not done: nothing retires.
        complete(2); complete(3); idle(2);
        // R5 bypass: complete slot 0 while reading its tag (arch 0 maps to 8).
        step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
        complete(1);
        idle(4);
        // R3: no-destination entries.
        step(1, 0, 5, 5, 6, 0, 0, 0, 0, 0);
        step(1, 0, 6, 5, 6, 0, 0, 0, 0, 0);
        // R4: scheduler full refuses.
        step(1, 1, 4, 4, 4, 1, 0, 0, 0, 0);
        // R7/R8: rollback three youngest while dispatch keeps asking.
        step(1, 1, 1, 1, 2, 0, 0, 0, 1, 3);
        for (int k = 0; k < 4; k++) step(1, 1, 1, 1, 2, 0, 0, 0, 0, 0);
        // R7: oversized rollback is clamped to the in-flight count.
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 15);
        idle(D + 2);
        // R7: zero-count rollback does nothing.
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        idle(NA);
        // Mixed traffic.
        for (int n = 0; n < 5000; n++) begin
            bit dv, hd, sf, cv, rq;
            int ci, rc;
            dv = ($urandom % 4) != 0;
            hd = ($urandom % 5) != 0;
            sf = ($urandom % 8) == 0;
            cv = 0; ci = 0; rq = 0; rc = 0;
            if (!m_rb && rcount > 0 && ($urandom % 2) == 1) begin
                cv = 1; ci = (rhead + int'($urandom % 32'(rcount))) % D;
            end
            if (!m_rb && ($urandom % 30) == 0) begin
                rq = 1; rc = int'($urandom % 32'(rcount + 2));
                cv = 0;
            end
            if (($urandom % 50) == 0) begin cv = 1; ci = (rhead + rcount) % D; end
            if (rq || m_rb) cv = 0;
            step(dv, hd, int'($urandom % NA), int'($urandom % NA), int'($urandom % NA),
                 sf, cv, ci, rq, rc);
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule